// File: doc/BRIEF.md
# Chip-Selected Configuration Bus Register Target

This block is the target side of a two-wire configuration bus of the SMBus kind. A fast system clock samples an open-drain clock line and data line. The block recognises bus framing, checks a 7-bit device address and gives the host write and read access to a small bank of 8-bit registers. After each data byte the register pointer moves on by one. This holds for both writes and reads, so a burst covers consecutive registers.

Several targets can carry the same device address on one shared bus. An active-high chip-select input decides which of them takes part. While chip select is low, the target does not react to the bus and never pulls the data line. A timer watches both lines. When they stay high long enough, it reports the bus as idle and sends the protocol engine back to its idle state. Two register values drive power-control outputs: one disables the input buffers and one powers down the output buffer.

Top module: `cfgbus_target`

## Requirements
- R1: A falling data line while the clock line is high is a START and begins reception of an address byte. A rising data line while the clock line is high is a STOP and returns the target to idle. A byte clocked without a preceding START is not acknowledged.
- R2: If bits 7:1 of the first byte after START equal `DEV_ADDR`, the target pulls the data line low during the ninth clock (ACK). If they differ, the line stays released, and no further byte is acknowledged until the next START or STOP.
- R3: In a write (address byte with bit 0 = 0), the second byte loads the register pointer. Each following byte is stored at the pointer, which then advances by one. Every such byte is acknowledged.
- R4: In a read (address byte with bit 0 = 1), the target shifts out the register at the pointer, MSB first, and advances the pointer. A ninth bit of 0 from the host requests another byte. A ninth bit of 1 ends the read and the target stops driving.
- R5: The pointer advances from `NREGS-1` to 0. Reads at addresses of `NREGS` and above return 0x00. Writes there leave the bank unchanged.
- R6: While `cs` is low the target never drives the data line and does not change its registers.
- R7: The data-line pull-down changes only after the synchronised clock line has been seen low. It never changes during a clock-high phase.
- R8: `bus_idle` goes high when both lines have been high for more than `T_BUF` cycles since a STOP. Without a STOP, it goes high after more than `T_HIGH_MAX` cycles. It goes low when either line goes low.
- R9: `in_buf_dis` is high exactly when register 0x26 holds 0x40. `out_pwr_dn` is high exactly when register 0x01 holds 0x10.
- R10: After reset, all registers are 0x00, `sda_oe` is 0 and both power-control outputs are 0.
- R11: A repeated START keeps the register pointer, so a read that follows a write of the register address starts at that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Active-high chip select that enables the bus interface |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| bus_idle | output | 1 | Bus-free timeout reached |
| in_buf_dis | output | 1 | Input-buffer disable, decoded from register 0x26 |
| out_pwr_dn | output | 1 | Output-buffer power-down, decoded from register 0x01 |
| reg_dump | output | NREGS*8 | All register contents, register i in bits 8i+7:8i |

## Verification
The hardest case to reach is a multi-byte burst that crosses the top of the register bank. The stimulus starts a write burst at register 38, so the third byte lands in register 0 and the fourth in register 1. A read burst from register 39 with host ACKs must then return those bytes across the same wrap and release the line after the final NACK. A second hard case is the idle timer's choice between its two limits. The bench measures it once right after reset, with no STOP seen, and once just after a STOP, sampling on both sides of each limit.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_REGADR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } tgt_state_e;

  // Next register pointer: wraps from the last implemented register to 0.
  function automatic logic [7:0] ptr_advance(input logic [7:0] p, input int unsigned nregs);
    if (32'(p) >= nregs - 1) return 8'h00;
    return p + 8'd1;
  endfunction

  function automatic logic addr_in_bank(input logic [7:0] a, input int unsigned nregs);
    return 32'(a) < nregs;
  endfunction

endpackage

// File: rtl/cfgb_sync.sv
module cfgb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
  assign ev_rise  = scl_s & ~scl_d;
  assign ev_fall  = ~scl_s & scl_d;

endmodule

// File: rtl/cfgb_idle.sv
module cfgb_idle #(
  parameter int T_BUF      = 20,
  parameter int T_HIGH_MAX = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic ev_start,
  input  logic ev_stop,
  output logic bus_idle
);
  localparam int MAXT = (T_BUF > T_HIGH_MAX) ? T_BUF : T_HIGH_MAX;
  localparam int CW   = $clog2(MAXT + 2);
  localparam logic [CW-1:0] BUF_LIM  = CW'(T_BUF);
  localparam logic [CW-1:0] HIGH_LIM = CW'(T_HIGH_MAX);

  logic [CW-1:0] cnt;
  logic          after_stop;
  logic          both_hi;
  logic [CW-1:0] lim;

  assign both_hi = scl_s & sda_s;
  assign lim     = after_stop ? BUF_LIM : HIGH_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      bus_idle   <= 1'b0;
      after_stop <= 1'b0;
    end else begin
      if (ev_stop)       after_stop <= 1'b1;
      else if (ev_start) after_stop <= 1'b0;
      if (!both_hi) begin
        cnt      <= '0;
        bus_idle <= 1'b0;
      end else if (!bus_idle) begin
        if (cnt >= lim) bus_idle <= 1'b1;
        else            cnt      <= cnt + 1'b1;
      end
    end
  end

  // R8: idle can only be reported after both lines were seen high
  p_idle_needs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_idle) |-> $past(scl_s && sda_s));

endmodule

// File: rtl/cfgb_regbank.sv
module cfgb_regbank
  import cfgb_pkg::*;
#(
  parameter int NREGS = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         rd_addr,
  output logic [7:0]         rd_data,
  output logic [NREGS*8-1:0] dump,
  output logic               in_buf_dis,
  output logic               out_pwr_dn
);
  localparam int IBD_REG = 'h26;
  localparam int OPD_REG = 'h01;

  logic [7:0] mem [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      for (int i = 0; i < NREGS; i++)
        if (wr_addr == 8'(i)) mem[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREGS; i++)
      if (rd_addr == 8'(i)) rd_data = mem[i];
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_dump
    assign dump[g*8 +: 8] = mem[g];
  end

  if (NREGS > IBD_REG) begin : g_ibd
    assign in_buf_dis = (mem[IBD_REG] == 8'h40);
  end else begin : g_no_ibd
    assign in_buf_dis = 1'b0;
  end

  if (NREGS > OPD_REG) begin : g_opd
    assign out_pwr_dn = (mem[OPD_REG] == 8'h10);
  end else begin : g_no_opd
    assign out_pwr_dn = 1'b0;
  end

  // R5: a write outside the bank leaves every register untouched
  p_oob_write_keeps_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_in_bank(wr_addr, NREGS)) |=> $stable(dump));

endmodule

// File: rtl/cfgbus_target.sv
module cfgbus_target
  import cfgb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter int         NREGS       = 40,
  parameter int         T_BUF       = 20,
  parameter int         T_HIGH_MAX  = 60,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic               bus_idle,
  output logic               in_buf_dis,
  output logic               out_pwr_dn,
  output logic [NREGS*8-1:0] reg_dump
);
  localparam logic [7:0] LAST_REG = 8'(NREGS - 1);

  logic scl_s, sda_s, ev_start, ev_stop, ev_rise, ev_fall;
  tgt_state_e state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txbyte, ptr, rd_data;
  logic       mack;
  logic       active, ack_open, ack_close, wr_en, dev_hit;

  cfgb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  cfgb_idle #(.T_BUF(T_BUF), .T_HIGH_MAX(T_HIGH_MAX)) u_idle (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .ev_start(ev_start), .ev_stop(ev_stop), .bus_idle(bus_idle)
  );

  cfgb_regbank #(.NREGS(NREGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(shreg),
    .rd_addr(ptr), .rd_data(rd_data), .dump(reg_dump),
    .in_buf_dis(in_buf_dis), .out_pwr_dn(out_pwr_dn)
  );

  // Named internal events
  assign active    = (state != ST_IDLE) && (state != ST_IGNORE);
  assign ack_open  = cs && active && ev_fall && (bitcnt == 4'd8);
  assign ack_close = cs && active && ev_fall && (bitcnt == 4'd9);
  assign wr_en     = ack_open && (state == ST_WDATA);
  assign dev_hit   = (shreg[7:1] == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= 4'd0;
      shreg  <= 8'h00;
      txbyte <= 8'h00;
      ptr    <= 8'h00;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (!cs) begin
      state  <= ST_IDLE;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (ev_start) begin
      state  <= ST_DEVADR;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (ev_stop || bus_idle) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (active) begin
      if (ev_rise) begin
        if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
        if (bitcnt == 4'd8 && state == ST_RDATA) mack <= ~sda_s;
        if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
      end else if (ack_open) begin
        unique case (state)
          ST_DEVADR: begin
            if (dev_hit) begin
              sda_oe <= 1'b1;
              mack   <= 1'b1;
              state  <= shreg[0] ? ST_RDATA : ST_REGADR;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_IGNORE;
            end
          end
          ST_REGADR: begin
            ptr    <= shreg;
            sda_oe <= 1'b1;
            state  <= ST_WDATA;
          end
          ST_WDATA: begin
            ptr    <= ptr_advance(ptr, NREGS);
            sda_oe <= 1'b1;
          end
          default: sda_oe <= 1'b0;
        endcase
      end else if (ack_close) begin
        bitcnt <= 4'd0;
        if (state == ST_RDATA) begin
          if (mack) begin
            txbyte <= rd_data;
            ptr    <= ptr_advance(ptr, NREGS);
            sda_oe <= ~rd_data[7];
          end else begin
            state  <= ST_IGNORE;
            sda_oe <= 1'b0;
          end
        end else begin
          sda_oe <= 1'b0;
        end
      end else if (ev_fall && state == ST_RDATA && bitcnt != 4'd0 && bitcnt < 4'd8) begin
        sda_oe <= ~txbyte[3'd7 - bitcnt[2:0]];
      end
    end
  end

  // R6: a deselected target releases the data line
  p_quiet_without_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !sda_oe);

  // R7: the pull-down is only switched on after the clock was seen low
  p_drive_on_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(!scl_s));

  // R2: after an address mismatch the target stays silent
  p_ignore_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_oe);

  // R5: a write at the last register sends the pointer back to 0
  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == LAST_REG) |=> (ptr == 8'h00));

endmodule

// File: tb/sim_cfgbus_target.sv
module sim_cfgbus_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int NREGS      = 40;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int NVEC = 6;
  // {register address, data}
  localparam logic [15:0] VEC [NVEC] = '{16'h00A5, 16'h0137, 16'h1F3C,
                                         16'h27FF, 16'h2A55, 16'h3099};

  logic clk = 1'b0;
  logic rst_n, cs, scl_m, sda_m;
  logic sda_oe, bus_idle, in_buf_dis, out_pwr_dn;
  logic [NREGS*8-1:0] dump;
  wire  sda_bus = sda_m & ~sda_oe;

  int nchk = 0, nfail = 0;
  int hi_cnt = 0, r7_bad = 0, r6_bad = 0;
  logic oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgbus_target #(.DEV_ADDR(DEV), .NREGS(NREGS), .T_BUF(20), .T_HIGH_MAX(60)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .bus_idle(bus_idle), .in_buf_dis(in_buf_dis),
    .out_pwr_dn(out_pwr_dn), .reg_dump(dump)
  );

  always @(negedge clk) begin
    if (scl_m === 1'b1) hi_cnt++; else hi_cnt = 0;
    if (sda_oe !== oe_prev && hi_cnt >= 4) r7_bad++;
    if (cs === 1'b0 && sda_oe === 1'b1) r6_bad++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic bstart();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0;
  endtask

  task automatic bstop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      qwait(); sda_m = b[i]; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0;
    end
    qwait(); sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); ack = ~sda_bus; qwait(); scl_m = 1'b0;
  endtask

  task automatic rbyte(input logic host_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      qwait(); sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); d[i] = sda_bus; qwait(); scl_m = 1'b0;
    end
    qwait(); sda_m = ~host_ack; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0;
  endtask

  // write address byte + register address, repeated START, read address byte
  task automatic rd_setup(input logic [7:0] a, output logic ok);
    logic k1, k2, k3;
    bstart(); wbyte({DEV, 1'b0}, k1); wbyte(a, k2);
    bstart(); wbyte({DEV, 1'b1}, k3);
    ok = k1 & k2 & k3;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic k, k2, k3;
    logic [7:0] d;
    logic [NREGS*8-1:0] snap;
    rst_n = 1'b0; cs = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 sda_oe", 32'(sda_oe), 0);
    chk("R10 regs zero", 32'(dump == '0), 1);
    chk("R10 power outputs", {30'd0, in_buf_dis, out_pwr_dn}, 0);
    // R8: without a STOP the longer limit applies
    repeat (30) @(negedge clk);
    chk("R8 idle not before high-time limit", 32'(bus_idle), 0);
    repeat (50) @(negedge clk);
    chk("R8 idle after high-time limit", 32'(bus_idle), 1);

    // Vector table: R3 write, R4/R11 read back after repeated START, R5 range
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] a, dv, ex;
      a = VEC[v][15:8]; dv = VEC[v][7:0];
      ex = (32'(a) < NREGS) ? dv : 8'h00;
      bstart(); wbyte({DEV, 1'b0}, k); wbyte(a, k2); wbyte(dv, k3); bstop();
      chk("R3 write acks", {29'd0, k, k2, k3}, 32'h7);
      rd_setup(a, k);
      rbyte(1'b0, d); bstop();
      chk("R11 read setup acks", 32'(k), 1);
      chk("R4/R5 read back", 32'(d), 32'(ex));
    end

    // R5 wrap on write burst; R9 decoded outputs
    bstart(); wbyte({DEV, 1'b0}, k); wbyte(8'd38, k);
    wbyte(8'h40, k); wbyte(8'h77, k); wbyte(8'h12, k); wbyte(8'h10, k2); bstop();
    chk("R3 burst last ack", 32'(k2), 1);
    chk("R5 wrap reg39", 32'(dump[39*8 +: 8]), 32'h77);
    chk("R5 wrap reg0", 32'(dump[0 +: 8]), 32'h12);
    chk("R5 wrap reg1", 32'(dump[8 +: 8]), 32'h10);
    chk("R9 in_buf_dis set", 32'(in_buf_dis), 1);
    chk("R9 out_pwr_dn set", 32'(out_pwr_dn), 1);

    // R8 after STOP: shorter limit
    repeat (8) @(negedge clk);
    chk("R8 idle not yet after stop", 32'(bus_idle), 0);
    repeat (30) @(negedge clk);
    chk("R8 idle after bus-free time", 32'(bus_idle), 1);

    // R4/R5 read burst across the wrap, host ACKs then NACK
    rd_setup(8'd39, k);
    rbyte(1'b1, d); chk("R4 burst byte0", 32'(d), 32'h77);
    rbyte(1'b1, d); chk("R5 burst wrap byte1", 32'(d), 32'h12);
    rbyte(1'b0, d); chk("R4 burst byte2", 32'(d), 32'h10);
    repeat (Q) @(negedge clk);
    chk("R4 released after NACK", 32'(sda_oe), 0);
    bstop();

    // R1: byte without START is not acknowledged
    scl_m = 1'b0; qwait();
    wbyte({DEV, 1'b0}, k);
    chk("R1 no ack without START", 32'(k), 0);
    scl_m = 1'b1; qwait(); bstop();

    // R2: address mismatch
    snap = dump;
    bstart(); wbyte({7'h11, 1'b0}, k); wbyte(8'h00, k2); wbyte(8'hEE, k3); bstop();
    chk("R2 mismatch no ack", {29'd0, k, k2, k3}, 0);
    chk("R2 mismatch bank unchanged", 32'(dump == snap), 1);

    // R6: chip select low
    cs = 1'b0; qwait();
    bstart(); wbyte({DEV, 1'b0}, k); wbyte(8'h00, k2); wbyte(8'h05, k3); bstop();
    chk("R6 no ack while deselected", {29'd0, k, k2, k3}, 0);
    chk("R6 bank unchanged", 32'(dump == snap), 1);
    cs = 1'b1; qwait();

    // R9: other value clears the decode
    bstart(); wbyte({DEV, 1'b0}, k); wbyte(8'h26, k); wbyte(8'h41, k); bstop();
    chk("R9 in_buf_dis cleared", 32'(in_buf_dis), 0);

    chk("R7 drive changes only with SCL low", 32'(r7_bad), 0);
    chk("R6 never driven while deselected", 32'(r6_bad), 0);
    finish_run();
  end

endmodule